// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

A bank of independent down-counting timers behind a word-wide register bus. A single bank-wide enable gates every channel. Each channel also has its own local enable, a reload value, a live count, a wrap counter, and a one-bit interrupt status with a matching mask. While a channel runs it decrements once per clock. When it passes zero it reloads, bumps its wrap counter and flags an interrupt. A reload of all ones turns a channel into a free-running source whose inverted count rises monotonically.

Software reads a channel's count through a latched copy. Reading the wrap-count register captures the live count into that copy in the same cycle. Reading the wrap count first and the count second therefore returns a pair taken at one instant. The bus has no back-pressure. A request is accepted in any cycle where `req_valid` is high. A read returns its data exactly one cycle later, with `rsp_valid` high for one cycle. Reads never stall, and writes produce no response.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0 (except the revision word), all channels are disabled and masked, `irq` is low and `rsp_valid` is low.
- R2: Offset 0x00 bit 0 is the bank-wide enable (read/write). Offset 0x10 returns the REVISION parameter. Every unmapped offset reads 0.
- R3: Channel n (0..NUM_CH-1) occupies base 0x20*(n+1) with these offsets: 0x00 config (bit 0 = local enable), 0x04 reload, 0x08 count copy, 0x0C wrap count, 0x10 status (bit 0), 0x14 clear, 0x18 mask (bit 0). A read accepted in cycle t gives `rsp_valid` high with its data in cycle t+1, and `rsp_valid` is low otherwise.
- R4: A channel's count moves only while both the bank enable and its local enable are 1, and then drops by exactly 1 per clock.
- R5: A config write that takes the local enable from 0 to 1 loads the count from the reload register on that edge.
- R6: A reload write is ignored while the channel's local enable is 1.
- R7: A running channel whose count is 0 loads its reload value on the next edge, increments its 32-bit wrap count (modulo 2^32) and sets status bit 0.
- R8: The count-copy register returns the live count captured at the edge where a wrap-count read was accepted. It keeps that value until the next wrap-count read, and the read data of that wrap-count read is the pre-edge wrap count.
- R9: A write to clear with bit 0 set clears status, but a wrap on the same edge keeps status at 1.
- R10: `irq` is high exactly when some channel has both status bit 0 and mask bit 0 set.
- R11: Writes to the revision, count-copy, wrap-count and status offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | 1 | OR of status AND mask over all channels |

## Verification
The bench builds the bank with four channels, 32-bit registers, an 8-bit address and a distinctive revision word. With these values every channel offset, the first unmapped channel slot and the top of the address space can all be reached. The bench uses small reload values, including 0 and 3, so that wraps, wrap-count increments and clear-versus-set collisions occur within a few cycles. A large reload held with the bank enable off shows that the count and its latched copy stay still.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned OFF_GLOBAL = 'h00;
  localparam int unsigned OFF_REV    = 'h10;
  localparam int unsigned CH_STRIDE_LG = 5;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CFG,
    RK_RELOAD,
    RK_COPY,
    RK_WRAPS,
    RK_STAT,
    RK_CLR,
    RK_MASK
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [CH_STRIDE_LG-1:0] off);
    case (off)
      5'h00:   return RK_CFG;
      5'h04:   return RK_RELOAD;
      5'h08:   return RK_COPY;
      5'h0C:   return RK_WRAPS;
      5'h10:   return RK_STAT;
      5'h14:   return RK_CLR;
      5'h18:   return RK_MASK;
      default: return RK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BLK_W = ADDR_W - CH_STRIDE_LG
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_global,
  output logic              hit_rev,
  output logic              hit_ch,
  output logic [CH_W-1:0]   ch_idx,
  output reg_kind_e         kind
);

  logic [BLK_W-1:0]        blk;
  logic [CH_STRIDE_LG-1:0] off;

  assign blk = addr[ADDR_W-1:CH_STRIDE_LG];
  assign off = addr[CH_STRIDE_LG-1:0];

  always_comb begin
    hit_global = (addr == ADDR_W'(OFF_GLOBAL));
    hit_rev    = (addr == ADDR_W'(OFF_REV));
    kind       = kind_of(off);
    hit_ch     = (blk != '0) && (int'(blk) <= NUM_CH) && (kind != RK_NONE);
    ch_idx     = CH_W'(blk - 1'b1);
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cfg_we,
  input  logic              reload_we,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic              wraps_re,
  output logic              en,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] copy,
  output logic [DATA_W-1:0] wraps,
  output logic              status,
  output logic              mask
);

  logic run;
  logic at_zero;
  logic wrap;
  logic start;

  assign run     = glob_en & en;
  assign at_zero = (count == '0);
  assign wrap    = run & at_zero;
  assign start   = cfg_we & wdata[0] & ~en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      reload <= '0;
      count  <= '0;
      copy   <= '0;
      wraps  <= '0;
      status <= 1'b0;
      mask   <= 1'b0;
    end else begin
      if (cfg_we) en <= wdata[0];
      if (reload_we && !en) reload <= wdata;

      if (start)     count <= reload;
      else if (run)  count <= at_zero ? reload : count - 1'b1;

      if (wrap) wraps <= wraps + 1'b1;

      if (wrap)                     status <= 1'b1;
      else if (clr_we && wdata[0])  status <= 1'b0;

      if (mask_we)  mask <= wdata[0];
      if (wraps_re) copy <= count;
    end
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          NUM_CH   = 4,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] REVISION = 32'h0002_0100,
  localparam int         CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);

  logic      hit_global, hit_rev, hit_ch;
  logic [CH_W-1:0] ch_idx;
  reg_kind_e kind;

  logic glob_en;

  logic [NUM_CH-1:0] cfg_we, reload_we, clr_we, mask_we, wraps_re;
  logic [NUM_CH-1:0] en_v, st_v, mask_v;
  logic [NUM_CH-1:0][DATA_W-1:0] rel_v, cnt_v, copy_v, wraps_v;

  logic wr_req, rd_req;
  assign wr_req = req_valid & req_write;
  assign rd_req = req_valid & ~req_write;

  tmr_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr       (req_addr),
    .hit_global (hit_global),
    .hit_rev    (hit_rev),
    .hit_ch     (hit_ch),
    .ch_idx     (ch_idx),
    .kind       (kind)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel          = hit_ch && (ch_idx == CH_W'(i));
    assign cfg_we[i]    = wr_req & sel & (kind == RK_CFG);
    assign reload_we[i] = wr_req & sel & (kind == RK_RELOAD);
    assign clr_we[i]    = wr_req & sel & (kind == RK_CLR);
    assign mask_we[i]   = wr_req & sel & (kind == RK_MASK);
    assign wraps_re[i]  = rd_req & sel & (kind == RK_WRAPS);

    tmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .glob_en   (glob_en),
      .wdata     (req_wdata),
      .cfg_we    (cfg_we[i]),
      .reload_we (reload_we[i]),
      .clr_we    (clr_we[i]),
      .mask_we   (mask_we[i]),
      .wraps_re  (wraps_re[i]),
      .en        (en_v[i]),
      .reload    (rel_v[i]),
      .count     (cnt_v[i]),
      .copy      (copy_v[i]),
      .wraps     (wraps_v[i]),
      .status    (st_v[i]),
      .mask      (mask_v[i])
    );
  end

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit_global) begin
      rd_mux = {{(DATA_W-1){1'b0}}, glob_en};
    end else if (hit_rev) begin
      rd_mux = DATA_W'(REVISION);
    end else if (hit_ch) begin
      case (kind)
        RK_CFG:    rd_mux = {{(DATA_W-1){1'b0}}, en_v[ch_idx]};
        RK_RELOAD: rd_mux = rel_v[ch_idx];
        RK_COPY:   rd_mux = copy_v[ch_idx];
        RK_WRAPS:  rd_mux = wraps_v[ch_idx];
        RK_STAT:   rd_mux = {{(DATA_W-1){1'b0}}, st_v[ch_idx]};
        RK_MASK:   rd_mux = {{(DATA_W-1){1'b0}}, mask_v[ch_idx]};
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_req && hit_global) glob_en <= req_wdata[0];
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
    end
  end

  assign irq = |(st_v & mask_v);

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_write,
  input logic                          rsp_valid,
  input logic                          irq,
  input logic                          glob_en,
  input logic [NUM_CH-1:0]             en_v,
  input logic [NUM_CH-1:0]             st_v,
  input logic [NUM_CH-1:0]             mask_v,
  input logic [NUM_CH-1:0]             cfg_we,
  input logic [NUM_CH-1:0]             clr_we,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_v,
  input logic [NUM_CH-1:0][DATA_W-1:0] rel_v
);

  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r3_rsp_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_v == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r7_wrap_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_en && en_v[i] && cnt_v[i] == '0) |=> st_v[i]);

    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_v[i]) |-> $past(clr_we[i]));

    a_r4_idle_without_global: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !cfg_we[i]) |=> $stable(cnt_v[i]));

    a_r6_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
      en_v[i] |=> $stable(rel_v[i]));
  end

endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .irq       (irq),
  .glob_en   (glob_en),
  .en_v      (en_v),
  .st_v      (st_v),
  .mask_v    (mask_v),
  .cfg_we    (cfg_we),
  .clr_we    (clr_we),
  .cnt_v     (cnt_v),
  .rel_v     (rel_v)
);

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;

  localparam int          NCH = 4;
  localparam logic [31:0] REV = 32'h0A0B_0C0D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  tmr_bank #(.NUM_CH(NCH), .DATA_W(32), .ADDR_W(8), .REVISION(REV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int unsigned m_cnt[NCH], m_rel[NCH], m_copy[NCH], m_wraps[NCH];
  bit          m_en[NCH], m_st[NCH], m_mask[NCH];
  bit          m_glob;
  bit          e_rsp_valid, e_irq;
  int unsigned e_rdata;
  string       e_tag;

  function automatic bit ch_dec(input int unsigned a, output int ch, output int off);
    ch  = int'(a / 32) - 1;
    off = int'(a % 32);
    return (a >= 32) && (a / 32 <= NCH) &&
           (off == 0 || off == 4 || off == 8 || off == 12 ||
            off == 16 || off == 20 || off == 24);
  endfunction

  function automatic int unsigned m_read(input int unsigned a, output string tag);
    int ch, off;
    tag = "R2";
    if (a == 0)     return {31'b0, m_glob};
    if (a == 'h10)  return REV;
    if (!ch_dec(a, ch, off)) return 0;
    case (off)
      0:  begin tag = "R4";  return {31'b0, m_en[ch]};   end
      4:  begin tag = "R6";  return m_rel[ch];          end
      8:  begin tag = "R8";  return m_copy[ch];         end
      12: begin tag = "R7";  return m_wraps[ch];        end
      16: begin tag = "R9";  return {31'b0, m_st[ch]};   end
      24: begin tag = "R10"; return {31'b0, m_mask[ch]}; end
      default: begin tag = "R11"; return 0; end
    endcase
  endfunction

  always @(posedge clk) begin
    int ch, off;
    bit mapped, old_en, run, wrap;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 0; m_rel[c] = 0; m_copy[c] = 0; m_wraps[c] = 0;
        m_en[c] = 0; m_st[c] = 0; m_mask[c] = 0;
      end
      m_glob = 0; e_rsp_valid = 0; e_rdata = 0; e_irq = 0;
    end else begin
      e_rsp_valid = req_valid && !req_write;
      if (e_rsp_valid) e_rdata = m_read(req_addr, e_tag);
      mapped = ch_dec(req_addr, ch, off);
      for (int c = 0; c < NCH; c++) begin
        old_en = m_en[c];
        run    = m_glob && old_en;
        wrap   = run && (m_cnt[c] == 0);
        if (req_valid && !req_write && mapped && ch == c && off == 12)
          m_copy[c] = m_cnt[c];
        if (run) begin
          if (wrap) begin m_cnt[c] = m_rel[c]; m_wraps[c]++; m_st[c] = 1; end
          else m_cnt[c]--;
        end
        if (req_valid && req_write && mapped && ch == c) begin
          case (off)
            0:  begin
                  if (!old_en && req_wdata[0]) m_cnt[c] = m_rel[c];
                  m_en[c] = req_wdata[0];
                end
            4:  if (!old_en) m_rel[c] = req_wdata;
            20: if (req_wdata[0] && !wrap) m_st[c] = 0;
            24: m_mask[c] = req_wdata[0];
            default: ;
          endcase
        end
      end
      if (req_valid && req_write && req_addr == 0) m_glob = req_wdata[0];
      e_irq = 0;
      for (int c = 0; c < NCH; c++) e_irq |= m_st[c] & m_mask[c];
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(irq == 1'b0, "R1 irq in reset", {31'b0, irq}, 0);
      check(rsp_valid == 1'b0, "R1 rsp_valid in reset", {31'b0, rsp_valid}, 0);
    end else if (!done) begin
      check(rsp_valid == e_rsp_valid, "R3 rsp_valid timing", {31'b0, rsp_valid},
            {31'b0, e_rsp_valid});
      if (e_rsp_valid)
        check(rsp_rdata == e_rdata, {e_tag, " read data"}, rsp_rdata, e_rdata);
      check(irq == e_irq, "R10 irq", {31'b0, irq}, {31'b0, e_irq});
    end
  end

  function automatic logic [7:0] ra(input int ch, input int off);
    return 8'(32 * (ch + 1) + off);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  task automatic rd(input logic [7:0] a);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1;
    // R1: everything clear after reset
    rd_expect(8'h00, 0, "R1 global enable");
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 28; o += 4) rd_expect(ra(c, o), 0, "R1 channel register");
    // R2: revision and unmapped offsets
    rd_expect(8'h10, REV, "R2 revision");
    rd_expect(8'h04, 0, "R2 unmapped low");
    rd_expect(8'h3C, 0, "R2 unmapped in-channel");
    rd_expect(8'hA0, 0, "R2 unmapped channel slot");
    rd_expect(8'hFC, 0, "R2 unmapped top");
    // R3: layout of channel 2
    wr(ra(2, 4), 32'h1234_5678);
    rd_expect(ra(2, 4), 32'h1234_5678, "R3 channel 2 reload");
    rd_expect(ra(1, 4), 0, "R3 channel 1 untouched");
    // R5/R4: load on enable, no motion with bank off
    wr(ra(0, 4), 100);
    wr(ra(0, 0), 1);
    rd(ra(0, 12));
    rd_expect(ra(0, 8), 100, "R5 load on enable");
    idle(6);
    rd(ra(0, 12));
    rd_expect(ra(0, 8), 100, "R4 frozen without bank enable");
    // R6: reload locked while enabled
    wr(ra(0, 4), 7);
    rd_expect(ra(0, 4), 100, "R6 reload ignored while enabled");
    // R11: read-only offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd_expect(8'h10, REV, "R11 revision write ignored");
    wr(ra(0, 12), 5);
    rd_expect(ra(0, 12), 0, "R11 wrap count write ignored");
    wr(ra(0, 16), 1);
    rd_expect(ra(0, 16), 0, "R11 status write ignored");
    // R7/R10: channel 1 wraps and interrupts
    wr(ra(1, 4), 3);
    wr(ra(1, 24), 1);
    wr(ra(1, 0), 1);
    wr(8'h00, 1);
    idle(12);
    rd_expect(ra(1, 16), 1, "R7 status after wrap");
    rd(ra(1, 12));
    rd(ra(1, 8));
    rd(ra(0, 12));
    idle(3);
    rd(ra(0, 8));               // R8: copy is stale, not live
    rd(ra(0, 8));
    wr(ra(1, 20), 1);
    idle(2);
    // R9: clear collides with a wrap every cycle
    wr(ra(3, 0), 1);
    wr(ra(3, 24), 1);
    wr(ra(3, 20), 1);
    rd_expect(ra(3, 16), 1, "R9 set wins over clear");
    wr(ra(3, 0), 0);
    wr(ra(3, 20), 1);
    rd_expect(ra(3, 16), 0, "R9 clear takes effect");
    wr(ra(1, 24), 0);
    idle(8);
    rd(ra(1, 12));
    rd(ra(1, 8));
    wr(8'h00, 0);
    idle(5);
    rd(ra(3, 12));
    rd(ra(0, 12));
    rd(ra(0, 8));
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule